// File: doc/BRIEF.md
# Machine-Cycle Status Word Generator

This block works out which kind of machine cycle an 8080-style processor is in and produces the 8-bit status word that the processor puts out in the first T-state of that cycle. The execution sequencer supplies the current opcode and a flat count of the T-states already completed within the instruction. It also supplies a flag saying whether that count is valid yet, the branch decision of a conditional instruction, the halted state, and the interrupt request and enable flags. The block then returns both the status byte and an enumerated cycle-kind code.

The cycle kind comes from a fixed priority. An enabled interrupt request comes first. A halted processor comes next. Otherwise the kind is looked up by placing the T-state count inside the opcode's machine-cycle layout. The first machine cycle takes 4 or 5 T-states and each later cycle takes 3. Both outputs are registered, so a change on the inputs shows on the outputs one clock later.

Top module: `cycle_status_gen`

## Requirements
- R1: Kind codes and status bytes: fetch 0/0xA2, memory read 1/0x82, memory write 2/0x00, stack read 3/0x86, stack write 4/0x04, input read 5/0x42, output write 6/0x10, interrupt acknowledge 7/0x23, halt acknowledge 8/0x8A. Status bit 7 down to bit 0 means memory read, input, first cycle, output, halt acknowledge, stack, write (active low), interrupt acknowledge.
- R2: While reset is low, the outputs hold kind 0 and status 0xA2.
- R3: When the interrupt request and the interrupt enable are both high, the kind is interrupt acknowledge, whether or not the processor is halted.
- R4: When the processor is halted and no enabled interrupt is pending, the kind is halt acknowledge.
- R5: An interrupt request with the enable low has no effect; the layout result is used.
- R6: While the phase-valid input is low (no T-state completed yet), the kind is fetch unless R3 or R4 applies.
- R7: A phase of 0 gives fetch for every opcode.
- R8: T-states below the first-cycle length (5 for 0xC5, 0xCD, 0xC4, 0xC0, 4 otherwise) are fetch. Each later cycle covers the next 3 T-states. A phase beyond the last cycle of the layout, or an opcode outside the set listed in R9 to R12, gives fetch.
- R9: Later cycles: 0x06 memory read; 0x01 two memory reads; 0x32 two memory reads then memory write; 0x3A three memory reads. Opcode 0x32 thus gives memory read at phases 4 and 7 and memory write at phase 10.
- R10: Opcode 0xDB gives a memory read then an input read, so phase 7 is input read. Opcode 0xD3 gives a memory read then an output write, so phase 7 is output write.
- R11: Opcode 0xC5 gives two stack writes from phase 5. Opcodes 0xC1 and 0xC9 each give two stack reads from phase 4. Opcode 0xCD gives two memory reads then two stack writes.
- R12: Opcode 0xC4 gives two memory reads, and then two stack writes only when branch-taken is high. Opcode 0xC0 gives two stack reads only when branch-taken is high. Branch-taken does not affect any other opcode.
- R13: Opcode 0x76 at phase 4 or above gives halt acknowledge, even without the halted flag.
- R14: Both outputs change exactly one clock after the inputs that select them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| opcode_i | input | 8 | Opcode of the instruction in progress |
| phase_i | input | PHASE_W (5) | T-states completed within the instruction |
| phase_valid_i | input | 1 | High once at least one T-state has completed |
| branch_taken_i | input | 1 | Branch decision of a conditional call or return |
| halted_i | input | 1 | Processor is in the halted state |
| int_req_i | input | 1 | Interrupt request pending |
| int_en_i | input | 1 | Interrupts enabled |
| status_o | output | 8 | Registered status byte |
| kind_o | output | 4 | Registered cycle-kind code |

## Verification
A vector table steps through every layout: the first T-state of each later cycle, its last T-state, and the first phase past the end. This separates an off-by-one in the cycle lengths from a wrong kind in a slot. Conditional opcodes are run with branch-taken both high and low, at the same phases, so that a layout ignoring the flag is caught. The halt opcode is tried just below, at and far above phase 4. Directed cases then combine halted, interrupt request and enable in every order of priority, hold phase-valid low with an opcode whose phase alone would give a write, and run phase 0 for all opcodes.

// File: rtl/csg_pkg.sv
package csg_pkg;

  typedef enum logic [3:0] {
    K_FETCH   = 4'd0,
    K_MEM_RD  = 4'd1,
    K_MEM_WR  = 4'd2,
    K_STK_RD  = 4'd3,
    K_STK_WR  = 4'd4,
    K_IO_RD   = 4'd5,
    K_IO_WR   = 4'd6,
    K_INT_ACK = 4'd7,
    K_HLT_ACK = 4'd8
  } kind_t;

  localparam int STATUS_W   = 8;
  localparam int MAX_LATER  = 4;               // longest layout after the first cycle
  localparam int CNT_W      = $clog2(MAX_LATER + 1);
  localparam int LATER_LEN  = 3;               // T-states per later machine cycle
  localparam logic [7:0] OP_HALT = 8'h76;
  localparam int HALT_PHASE = 4;

  // Status bit positions (bit 7 down to bit 0 is the external order)
  localparam int SB_MEMR  = 7;
  localparam int SB_INP   = 6;
  localparam int SB_M1    = 5;
  localparam int SB_OUT   = 4;
  localparam int SB_HLTA  = 3;
  localparam int SB_STACK = 2;
  localparam int SB_WR_N  = 1;
  localparam int SB_INTA  = 0;

  function automatic logic [STATUS_W-1:0] encode_status(input kind_t k);
    logic [STATUS_W-1:0] s;
    s = '0;
    s[SB_MEMR]  = (k == K_FETCH) || (k == K_MEM_RD) || (k == K_STK_RD) || (k == K_HLT_ACK);
    s[SB_INP]   = (k == K_IO_RD);
    s[SB_M1]    = (k == K_FETCH) || (k == K_INT_ACK);
    s[SB_OUT]   = (k == K_IO_WR);
    s[SB_HLTA]  = (k == K_HLT_ACK);
    s[SB_STACK] = (k == K_STK_RD) || (k == K_STK_WR);
    s[SB_WR_N]  = !((k == K_MEM_WR) || (k == K_STK_WR) || (k == K_IO_WR));
    s[SB_INTA]  = (k == K_INT_ACK);
    return s;
  endfunction

  function automatic logic is_write_kind(input kind_t k);
    return (k == K_MEM_WR) || (k == K_STK_WR) || (k == K_IO_WR);
  endfunction

endpackage

// File: rtl/csg_layout.sv
module csg_layout
  import csg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [7:0]                  opcode_i,
  input  logic                        taken_i,
  output logic [2:0]                  m1_len_o,
  output logic [CNT_W-1:0]            n_later_o,
  output kind_t [MAX_LATER-1:0]       kinds_o
);

  always_comb begin
    m1_len_o  = 3'd4;
    n_later_o = '0;
    for (int i = 0; i < MAX_LATER; i++) kinds_o[i] = K_FETCH;
    case (opcode_i)
      8'h06: begin
        n_later_o  = CNT_W'(1);
        kinds_o[0] = K_MEM_RD;
      end
      8'h01: begin
        n_later_o  = CNT_W'(2);
        kinds_o[0] = K_MEM_RD;
        kinds_o[1] = K_MEM_RD;
      end
      8'h32: begin
        n_later_o  = CNT_W'(3);
        kinds_o[0] = K_MEM_RD;
        kinds_o[1] = K_MEM_RD;
        kinds_o[2] = K_MEM_WR;
      end
      8'h3A: begin
        n_later_o  = CNT_W'(3);
        kinds_o[0] = K_MEM_RD;
        kinds_o[1] = K_MEM_RD;
        kinds_o[2] = K_MEM_RD;
      end
      8'hDB: begin
        n_later_o  = CNT_W'(2);
        kinds_o[0] = K_MEM_RD;
        kinds_o[1] = K_IO_RD;
      end
      8'hD3: begin
        n_later_o  = CNT_W'(2);
        kinds_o[0] = K_MEM_RD;
        kinds_o[1] = K_IO_WR;
      end
      8'hC5: begin
        m1_len_o   = 3'd5;
        n_later_o  = CNT_W'(2);
        kinds_o[0] = K_STK_WR;
        kinds_o[1] = K_STK_WR;
      end
      8'hC1, 8'hC9: begin
        n_later_o  = CNT_W'(2);
        kinds_o[0] = K_STK_RD;
        kinds_o[1] = K_STK_RD;
      end
      8'hCD: begin
        m1_len_o   = 3'd5;
        n_later_o  = CNT_W'(4);
        kinds_o[0] = K_MEM_RD;
        kinds_o[1] = K_MEM_RD;
        kinds_o[2] = K_STK_WR;
        kinds_o[3] = K_STK_WR;
      end
      8'hC4: begin
        m1_len_o   = 3'd5;
        n_later_o  = taken_i ? CNT_W'(4) : CNT_W'(2);
        kinds_o[0] = K_MEM_RD;
        kinds_o[1] = K_MEM_RD;
        kinds_o[2] = K_STK_WR;
        kinds_o[3] = K_STK_WR;
      end
      8'hC0: begin
        m1_len_o   = 3'd5;
        n_later_o  = taken_i ? CNT_W'(2) : CNT_W'(0);
        kinds_o[0] = K_STK_RD;
        kinds_o[1] = K_STK_RD;
      end
      default: begin
        n_later_o = '0;
      end
    endcase
  end

  // Layout never declares more later cycles than the slot array holds
  AST_LAYOUT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    n_later_o <= CNT_W'(MAX_LATER)); // R8
  // First cycle is 4 or 5 T-states long
  AST_M1_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_len_o == 3'd4) || (m1_len_o == 3'd5)); // R8

endmodule

// File: rtl/csg_locate.sv
module csg_locate
  import csg_pkg::*;
#(
  parameter int PHASE_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PHASE_W-1:0]     phase_i,
  input  logic [2:0]             m1_len_i,
  input  logic [CNT_W-1:0]       n_later_i,
  output logic                   in_m1_o,
  output logic [MAX_LATER-1:0]   slot_hit_o
);

  localparam int SW = PHASE_W + 3;

  logic [SW-1:0] ph_ext;
  assign ph_ext  = SW'(phase_i);
  assign in_m1_o = ph_ext < SW'(m1_len_i);

  for (genvar k = 0; k < MAX_LATER; k++) begin : g_slot
    logic [SW-1:0] lo;
    logic [SW-1:0] hi;
    assign lo = SW'(m1_len_i) + SW'(LATER_LEN * k);
    assign hi = lo + SW'(LATER_LEN);
    assign slot_hit_o[k] = (CNT_W'(k) < n_later_i) && (ph_ext >= lo) && (ph_ext < hi);
  end

  // At most one later cycle claims a given phase
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit_o)); // R8
  // A phase inside the first cycle never falls into a later slot
  AST_M1_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_m1_o |-> (slot_hit_o == '0)); // R8

endmodule

// File: rtl/cycle_status_gen.sv
module cycle_status_gen
  import csg_pkg::*;
#(
  parameter int PHASE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         opcode_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               phase_valid_i,
  input  logic               branch_taken_i,
  input  logic               halted_i,
  input  logic               int_req_i,
  input  logic               int_en_i,
  output logic [7:0]         status_o,
  output logic [3:0]         kind_o
);

  logic [2:0]             m1_len;
  logic [CNT_W-1:0]       n_later;
  kind_t [MAX_LATER-1:0]  kinds;
  logic                   in_m1;
  logic [MAX_LATER-1:0]   slot_hit;

  csg_layout u_layout (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode_i  (opcode_i),
    .taken_i   (branch_taken_i),
    .m1_len_o  (m1_len),
    .n_later_o (n_later),
    .kinds_o   (kinds)
  );

  csg_locate #(.PHASE_W(PHASE_W)) u_locate (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (phase_i),
    .m1_len_i   (m1_len),
    .n_later_i  (n_later),
    .in_m1_o    (in_m1),
    .slot_hit_o (slot_hit)
  );

  // Named decision events
  logic  inta_win;
  logic  halt_win;
  logic  hlt_op_hold;
  kind_t table_kind;
  kind_t next_kind;
  kind_t kind_q;
  logic [STATUS_W-1:0] status_q;

  assign inta_win    = int_req_i && int_en_i;
  assign halt_win    = halted_i && !inta_win;
  assign hlt_op_hold = phase_valid_i && (opcode_i == OP_HALT)
                       && (phase_i >= PHASE_W'(HALT_PHASE));

  always_comb begin
    table_kind = K_FETCH;
    for (int k = 0; k < MAX_LATER; k++) begin
      if (slot_hit[k]) table_kind = kinds[k];
    end
  end

  always_comb begin
    if (inta_win)            next_kind = K_INT_ACK;
    else if (halted_i)       next_kind = K_HLT_ACK;
    else if (!phase_valid_i) next_kind = K_FETCH;
    else if (hlt_op_hold)    next_kind = K_HLT_ACK;
    else if (in_m1)          next_kind = K_FETCH;
    else                     next_kind = table_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= K_FETCH;
      status_q <= encode_status(K_FETCH);
    end else begin
      kind_q   <= next_kind;
      status_q <= encode_status(next_kind);
    end
  end

  assign kind_o   = kind_q;
  assign status_o = status_q;

  AST_INTA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    inta_win |=> (kind_o == K_INT_ACK)); // R3
  AST_HALT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    halt_win |=> (kind_o == K_HLT_ACK)); // R4
  AST_COLD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_valid_i && !halted_i && !inta_win) |=> (status_o == 8'hA2)); // R6
  AST_PHASE0_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid_i && phase_i == '0 && !halted_i && !inta_win) |=> (kind_o == K_FETCH)); // R7
  AST_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[SB_WR_N] == !is_write_kind(kind_t'(kind_o))); // R1
  AST_HLT_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (hlt_op_hold && !inta_win) |=> (status_o == 8'h8A)); // R13

endmodule

// File: tb/cycle_status_gen_tb.sv
module cycle_status_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opcode_i = 8'h00;
  logic [4:0] phase_i = 5'd0;
  logic       phase_valid_i = 1'b0;
  logic       branch_taken_i = 1'b0;
  logic       halted_i = 1'b0;
  logic       int_req_i = 1'b0;
  logic       int_en_i = 1'b0;
  logic [7:0] status_o;
  logic [3:0] kind_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cycle_status_gen #(.PHASE_W(5)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .opcode_i       (opcode_i),
    .phase_i        (phase_i),
    .phase_valid_i  (phase_valid_i),
    .branch_taken_i (branch_taken_i),
    .halted_i       (halted_i),
    .int_req_i      (int_req_i),
    .int_en_i       (int_en_i),
    .status_o       (status_o),
    .kind_o         (kind_o)
  );

  // Status byte expected for each kind code (R1)
  function automatic logic [7:0] exp_byte(input logic [3:0] k);
    case (k)
      4'd0: return 8'hA2;
      4'd1: return 8'h82;
      4'd2: return 8'h00;
      4'd3: return 8'h86;
      4'd4: return 8'h04;
      4'd5: return 8'h42;
      4'd6: return 8'h10;
      4'd7: return 8'h23;
      default: return 8'h8A;
    endcase
  endfunction

  // {opcode, phase, taken, expected kind}
  localparam int NV = 38;
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 5'd0,  1'b0, 4'd0},  // R7
    {8'h00, 5'd4,  1'b0, 4'd0},  // R8 past end
    {8'h40, 5'd3,  1'b0, 4'd0},  // R8
    {8'h06, 5'd4,  1'b0, 4'd1},  // R9
    {8'h06, 5'd6,  1'b0, 4'd1},  // R9
    {8'h06, 5'd7,  1'b0, 4'd0},  // R8 past end
    {8'h01, 5'd8,  1'b0, 4'd1},  // R9
    {8'h01, 5'd10, 1'b0, 4'd0},  // R8
    {8'h32, 5'd4,  1'b0, 4'd1},  // R9
    {8'h32, 5'd7,  1'b0, 4'd1},  // R9
    {8'h32, 5'd10, 1'b0, 4'd2},  // R9
    {8'h32, 5'd12, 1'b1, 4'd2},  // R9 taken ignored R12
    {8'h32, 5'd13, 1'b0, 4'd0},  // R8
    {8'h3A, 5'd10, 1'b0, 4'd1},  // R9
    {8'hDB, 5'd4,  1'b0, 4'd1},  // R10
    {8'hDB, 5'd7,  1'b0, 4'd5},  // R10
    {8'hD3, 5'd7,  1'b0, 4'd6},  // R10
    {8'hD3, 5'd10, 1'b0, 4'd0},  // R8
    {8'hC5, 5'd4,  1'b0, 4'd0},  // R8 five-state first cycle
    {8'hC5, 5'd5,  1'b0, 4'd4},  // R11
    {8'hC5, 5'd10, 1'b0, 4'd4},  // R11
    {8'hC5, 5'd11, 1'b0, 4'd0},  // R8
    {8'hC1, 5'd4,  1'b0, 4'd3},  // R11
    {8'hC1, 5'd9,  1'b0, 4'd3},  // R11
    {8'hC9, 5'd7,  1'b0, 4'd3},  // R11
    {8'hCD, 5'd5,  1'b0, 4'd1},  // R11
    {8'hCD, 5'd11, 1'b0, 4'd4},  // R11
    {8'hCD, 5'd16, 1'b0, 4'd4},  // R11
    {8'hCD, 5'd17, 1'b0, 4'd0},  // R8
    {8'hC4, 5'd11, 1'b1, 4'd4},  // R12
    {8'hC4, 5'd11, 1'b0, 4'd0},  // R12
    {8'hC4, 5'd10, 1'b0, 4'd1},  // R12
    {8'hC0, 5'd5,  1'b1, 4'd3},  // R12
    {8'hC0, 5'd5,  1'b0, 4'd0},  // R12
    {8'h76, 5'd3,  1'b0, 4'd0},  // R13 below threshold
    {8'h76, 5'd4,  1'b0, 4'd8},  // R13
    {8'h76, 5'd20, 1'b0, 4'd8},  // R13
    {8'hFF, 5'd5,  1'b0, 4'd0}   // R8 unknown opcode
  };

  task automatic run(input logic [7:0] op, input logic [4:0] ph, input logic v,
                     input logic tk, input logic hl, input logic iq, input logic ie,
                     input logic [3:0] ek, input string tag);
    @(negedge clk);
    opcode_i = op; phase_i = ph; phase_valid_i = v; branch_taken_i = tk;
    halted_i = hl; int_req_i = iq; int_en_i = ie;
    @(negedge clk);
    checks++;
    if (kind_o !== ek || status_o !== exp_byte(ek)) begin
      errors++;
      $display("FAIL %s op=%02h ph=%0d: kind=%0d status=%02h expected kind=%0d status=%02h",
               tag, op, ph, kind_o, status_o, ek, exp_byte(ek));
    end
  endtask

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    opcode_i = 8'h32; phase_i = 5'd10; phase_valid_i = 1'b1;
    @(negedge clk);
    checks++;
    if (kind_o !== 4'd0 || status_o !== 8'hA2) begin
      errors++;
      $display("FAIL R2 reset: kind=%0d status=%02h expected kind=0 status=a2", kind_o, status_o);
    end
    rst_n = 1'b1;

    // Layout table walk (R1, R8 to R13)
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][17:10], VEC[i][9:5], 1'b1, VEC[i][4], 1'b0, 1'b0, 1'b0, VEC[i][3:0], "R8-table");
    end

    // R14: output follows one clock later; check the cycle in between
    @(negedge clk);
    opcode_i = 8'hD3; phase_i = 5'd7; phase_valid_i = 1'b1; halted_i = 1'b0;
    int_req_i = 1'b0; int_en_i = 1'b0; branch_taken_i = 1'b0;
    @(negedge clk);
    opcode_i = 8'hC5; phase_i = 5'd5;
    #1;
    checks++;
    if (kind_o !== 4'd6) begin
      errors++;
      $display("FAIL R14 latency: kind=%0d expected 6", kind_o);
    end
    @(negedge clk);
    checks++;
    if (kind_o !== 4'd4) begin
      errors++;
      $display("FAIL R14 latency: kind=%0d expected 4", kind_o);
    end

    // R6: phase not valid yet
    run(8'h32, 5'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R6 cold start");
    run(8'h76, 5'd9,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, "R6 cold halt opcode");
    // R4: halted
    run(8'h32, 5'd10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8, "R4 halted");
    run(8'h32, 5'd10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8, "R4 halted irq disabled");
    // R3: interrupt acknowledge priority
    run(8'h76, 5'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7, "R3 over halt");
    run(8'h32, 5'd10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7, "R3 running");
    run(8'h00, 5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7, "R3 cold");
    // R5: request without enable ignored
    run(8'h32, 5'd10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2, "R5 write kept");
    run(8'h00, 5'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, "R5 fetch kept");
    run(8'h00, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, "R5 enable alone");

    // R7: phase 0 of every opcode
    begin
      logic [7:0] ops [14] = '{8'h00, 8'h40, 8'h06, 8'h01, 8'h32, 8'h3A, 8'hC5,
                               8'hC1, 8'hCD, 8'hC9, 8'hDB, 8'hD3, 8'hC4, 8'h76};
      for (int j = 0; j < 14; j++) begin
        run(ops[j], 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, "R7 phase zero");
      end
    end

    // R2: reset again mid-run returns to fetch
    @(negedge clk);
    opcode_i = 8'h32; phase_i = 5'd10; phase_valid_i = 1'b1; halted_i = 1'b1;
    rst_n = 1'b0;
    #1;
    checks++;
    if (kind_o !== 4'd0 || status_o !== 8'hA2) begin
      errors++;
      $display("FAIL R2 reset again: kind=%0d status=%02h expected kind=0 status=a2", kind_o, status_o);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule